// File: doc/BRIEF.md
# DSI Command Packet Engine

This block turns one command description into a serial byte stream for a MIPI DSI link and then waits for the peripheral's answer. A 16-bit settings word gives the command kind (write, read or tearing-effect request), the packet length format, the virtual channel, the payload size, the low-power flag and the data type. Up to four 32-bit data words supply the payload. A single-cycle send strobe starts the command. The bytes leave on a valid/ready lane interface, and each byte carries a low-power marker.

After the last byte, the engine waits until the responder reports an acknowledge, a read reply, a tearing-effect trigger or an error. The outcome is recorded in sticky status flags. A clear mask drops flags by writing ones. An enable mask selects which flags may raise the interrupt output. The engine rejects payloads that are too long and ignores send strobes that arrive while it is busy. Each of these cases raises its own flag.

Top module: `dsi_cmd_engine`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `tx_last` and `irq` are low and `sts` is all zero.
- R2: Settings fields: nature [1:0] (0 write, 1 read, 2 tearing-effect request, 3 handled as write), long flag [2], virtual channel [4:3], size [8:5], low-power [9], data type [15:10]. A short packet is four bytes: {channel, type}, payload byte 0 (or 0 if size < 1), payload byte 1 (or 0 if size < 2), then ECC equal to the XOR of those three bytes. `tx_last` is high on the fourth byte.
- R3: A long packet has header bytes {channel, type}, size, 0x00 and ECC. Payload byte i is taken from bits 8*(i mod 4) of data word i/4. It is followed by the 16-bit sum of the payload bytes, low byte first. An empty long packet still carries the two checksum bytes.
- R4: A size above MAX_BYTES (12) on a non-tearing-effect command sends no byte, leaves `busy` low and sets flag bit 5.
- R5: Flag bit 0 sets in the cycle after the last byte is accepted. The engine then stays busy until `rsp_valid`.
- R6: A response with `rsp_err` sets flag bit 2 and stores `rsp_err_val` in `sts[31:16]`. For a read command it also sets flag bit 3.
- R7: A read that completes without error stores `rsp_data` in `rd_data` and min(`rsp_size`, 4) in `rd_size`, and sets flag bit 6.
- R8: A tearing-effect request ignores the channel, type, size and low-power fields. It sends the short packet 0x15, byte 0, byte 1, ECC with `tx_lp` high. A clean response sets flag bit 1.
- R9: For write and read commands, `tx_lp` equals the low-power field on every byte.
- R10: A send strobe while busy is ignored, so only one packet goes out, and it sets flag bit 4.
- R11: Flags are sticky. A one in `clr_mask` clears the matching flag and leaves the others unchanged.
- R12: `irq` is high exactly when some flag and its `irq_en` bit are both set.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Command settings word |
| wr_data | input | 128 | Four payload words, word 0 in the low bits |
| send | input | 1 | Start strobe |
| clr_mask | input | 7 | Write-one-to-clear flag mask |
| irq_en | input | 7 | Interrupt enable per flag |
| tx_valid | output | 1 | Byte valid |
| tx_byte | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_lp | output | 1 | Byte goes out in low-power mode |
| tx_ready | input | 1 | Lane accepts byte |
| rsp_valid | input | 1 | Peripheral response strobe |
| rsp_err | input | 1 | Response is an error acknowledge |
| rsp_err_val | input | 16 | Error value reported by the peripheral |
| rsp_data | input | 32 | Read reply bytes, little-endian |
| rsp_size | input | 3 | Read reply byte count |
| busy | output | 1 | Command in flight |
| sts | output | 32 | Flags [6:0], error value [31:16] |
| rd_data | output | 32 | Captured read reply |
| rd_size | output | 3 | Valid bytes in rd_data |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the engine with its default parameters: four data words and a 12-byte payload cap. A 12-byte long write fills exactly three words and reaches the deepest payload index. A 13-byte request lands one past the cap and exercises the reject path. A zero-length long write and an oversized read reply (6 bytes clamped to 4) cover the other size edges. The fourth data word is never reachable as payload at these values.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;

   localparam int SZ_W  = 4;
   localparam int FLG_W = 7;

   localparam int F_WR_DONE = 0;
   localparam int F_TE      = 1;
   localparam int F_ACK_ERR = 2;
   localparam int F_RD_ERR  = 3;
   localparam int F_COLLIDE = 4;
   localparam int F_SIZE    = 5;
   localparam int F_RD_DONE = 6;

   localparam logic [5:0] DT_TE_SHORT = 6'h15;

   typedef enum logic [1:0] {
      NAT_WRITE = 2'd0,
      NAT_READ  = 2'd1,
      NAT_TE    = 2'd2,
      NAT_RSVD  = 2'd3
   } nature_e;

   typedef struct packed {
      logic [5:0]      dtype;
      logic            lp;
      logic [SZ_W-1:0] size;
      logic [1:0]      vc;
      logic            is_long;
      nature_e         nature;
   } cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_PAY,
      ST_CRC,
      ST_WAIT
   } tx_state_e;

   function automatic logic [7:0] hdr_ecc(input logic [7:0] a,
                                          input logic [7:0] b,
                                          input logic [7:0] c);
      return a ^ b ^ c;
   endfunction

endpackage

// File: rtl/dsi_cmd_hdr.sv
module dsi_cmd_hdr
   import dsi_cmd_pkg::*;
#(
   parameter int MAX_BYTES = 12
) (
   input  cfg_t            cfg,
   input  logic [15:0]     lead_bytes,
   output logic [31:0]     hdr,
   output logic [SZ_W-1:0] pay_len,
   output logic            is_long,
   output logic            lp,
   output logic            is_read,
   output logic            is_te,
   output logic            size_bad
);

   logic [7:0] di, p1, p2;

   always_comb begin
      is_te   = (cfg.nature == NAT_TE);
      is_read = (cfg.nature == NAT_READ);
      if (is_te) begin
         di       = {2'b00, DT_TE_SHORT};
         p1       = lead_bytes[7:0];
         p2       = lead_bytes[15:8];
         is_long  = 1'b0;
         lp       = 1'b1;
         pay_len  = '0;
         size_bad = 1'b0;
      end else begin
         di       = {cfg.vc, cfg.dtype};
         lp       = cfg.lp;
         is_long  = cfg.is_long;
         size_bad = (int'(cfg.size) > MAX_BYTES);
         if (cfg.is_long) begin
            p1      = 8'(cfg.size);
            p2      = 8'h00;
            pay_len = cfg.size;
         end else begin
            p1      = (cfg.size >= 1) ? lead_bytes[7:0]  : 8'h00;
            p2      = (cfg.size >= 2) ? lead_bytes[15:8] : 8'h00;
            pay_len = '0;
         end
      end
      hdr = {hdr_ecc(di, p1, p2), p2, p1, di};
   end

endmodule

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx
   import dsi_cmd_pkg::*;
#(
   parameter int WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       hdr,
   input  logic [SZ_W-1:0]   pay_len,
   input  logic              is_long,
   input  logic              lp,
   input  logic              is_read,
   input  logic              is_te,
   input  logic [32*WORDS-1:0] wr_data,
   input  logic              tx_ready,
   input  logic              rsp_valid,
   input  logic              rsp_err,
   input  logic [15:0]       rsp_err_val,
   input  logic [31:0]       rsp_data,
   input  logic [2:0]        rsp_size,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   output logic              tx_last,
   output logic              tx_lp,
   output logic              busy,
   output logic              ev_wr_done,
   output logic              ev_te,
   output logic              ev_ack_err,
   output logic              ev_rd_err,
   output logic              ev_rd_done,
   output logic [15:0]       err_val,
   output logic [31:0]       rd_data,
   output logic [2:0]        rd_size
);

   localparam int DW     = 32 * WORDS;
   localparam int DIDX_W = $clog2(DW);

   tx_state_e         state;
   logic [SZ_W-1:0]   idx;
   logic [31:0]       hdr_q;
   logic [DW-1:0]     data_q;
   logic [SZ_W-1:0]   len_q;
   logic              long_q, lp_q, rd_q, te_q;
   logic [15:0]       csum;
   logic              fire;
   logic              resp;
   logic [DIDX_W-1:0] pay_sel;
   logic [4:0]        hdr_sel;

   assign pay_sel = DIDX_W'({idx, 3'b000});
   assign hdr_sel = {idx[1:0], 3'b000};

   always_comb begin
      tx_valid = (state == ST_HDR) || (state == ST_PAY) || (state == ST_CRC);
      unique case (state)
         ST_HDR:  tx_byte = hdr_q[hdr_sel +: 8];
         ST_PAY:  tx_byte = data_q[pay_sel +: 8];
         ST_CRC:  tx_byte = idx[0] ? csum[15:8] : csum[7:0];
         default: tx_byte = 8'h00;
      endcase
      tx_last = ((state == ST_HDR) && (idx == SZ_W'(3)) && !long_q) ||
                ((state == ST_CRC) && (idx == SZ_W'(1)));
   end

   assign tx_lp      = lp_q;
   assign busy       = (state != ST_IDLE);
   assign fire       = tx_valid && tx_ready;
   assign resp       = (state == ST_WAIT) && rsp_valid;
   assign ev_wr_done = fire && tx_last;
   assign ev_ack_err = resp && rsp_err;
   assign ev_rd_err  = resp && rsp_err && rd_q;
   assign ev_rd_done = resp && !rsp_err && rd_q;
   assign ev_te      = resp && !rsp_err && te_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         hdr_q   <= '0;
         data_q  <= '0;
         len_q   <= '0;
         long_q  <= 1'b0;
         lp_q    <= 1'b0;
         rd_q    <= 1'b0;
         te_q    <= 1'b0;
         csum    <= '0;
         err_val <= '0;
         rd_data <= '0;
         rd_size <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_HDR;
                  idx    <= '0;
                  csum   <= '0;
                  hdr_q  <= hdr;
                  data_q <= wr_data;
                  len_q  <= pay_len;
                  long_q <= is_long;
                  lp_q   <= lp;
                  rd_q   <= is_read;
                  te_q   <= is_te;
               end
            end
            ST_HDR: begin
               if (fire) begin
                  if (idx == SZ_W'(3)) begin
                     idx <= '0;
                     if (!long_q)            state <= ST_WAIT;
                     else if (len_q != '0)   state <= ST_PAY;
                     else                    state <= ST_CRC;
                  end else begin
                     idx <= idx + SZ_W'(1);
                  end
               end
            end
            ST_PAY: begin
               if (fire) begin
                  csum <= csum + {8'h00, tx_byte};
                  if (idx == SZ_W'(len_q - SZ_W'(1))) begin
                     idx   <= '0;
                     state <= ST_CRC;
                  end else begin
                     idx <= idx + SZ_W'(1);
                  end
               end
            end
            ST_CRC: begin
               if (fire) begin
                  idx <= idx + SZ_W'(1);
                  if (idx == SZ_W'(1)) state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  state <= ST_IDLE;
                  if (rsp_err) begin
                     err_val <= rsp_err_val;
                  end else if (rd_q) begin
                     rd_data <= rsp_data;
                     rd_size <= (rsp_size > 3'd4) ? 3'd4 : rsp_size;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dsi_cmd_status.sv
module dsi_cmd_status #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_ev,
   input  logic [W-1:0] clr_mask,
   input  logic [W-1:0] irq_en,
   output logic [W-1:0] flags,
   output logic         irq
);

   for (genvar i = 0; i < W; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)         flags[i] <= 1'b0;
         else if (set_ev[i]) flags[i] <= 1'b1;
         else if (clr_mask[i]) flags[i] <= 1'b0;
      end
   end

   assign irq = |(flags & irq_en);

endmodule

// File: rtl/dsi_cmd_engine.sv
module dsi_cmd_engine
   import dsi_cmd_pkg::*;
#(
   parameter int WORDS     = 4,
   parameter int MAX_BYTES = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        cfg_word,
   input  logic [32*WORDS-1:0] wr_data,
   input  logic               send,
   input  logic [6:0]         clr_mask,
   input  logic [6:0]         irq_en,
   output logic               tx_valid,
   output logic [7:0]         tx_byte,
   output logic               tx_last,
   output logic               tx_lp,
   input  logic               tx_ready,
   input  logic               rsp_valid,
   input  logic               rsp_err,
   input  logic [15:0]        rsp_err_val,
   input  logic [31:0]        rsp_data,
   input  logic [2:0]         rsp_size,
   output logic               busy,
   output logic [31:0]        sts,
   output logic [31:0]        rd_data,
   output logic [2:0]         rd_size,
   output logic               irq
);

   if (MAX_BYTES > 4 * WORDS || MAX_BYTES > (1 << SZ_W) - 1 || MAX_BYTES < 1) begin : g_bad_cfg
      $error("dsi_cmd_engine: MAX_BYTES must fit the data words and the size field");
   end

   cfg_t            cfg;
   logic [31:0]     hdr;
   logic [SZ_W-1:0] pay_len;
   logic            is_long, lp, is_read, is_te, size_bad;
   logic            ev_wr_done, ev_te, ev_ack_err, ev_rd_err, ev_rd_done;
   logic            send_ok, start;
   logic [15:0]     err_val;
   logic [FLG_W-1:0] set_ev, flags;

   assign cfg = cfg_t'(cfg_word);

   dsi_cmd_hdr #(.MAX_BYTES(MAX_BYTES)) u_hdr (
      .cfg        (cfg),
      .lead_bytes (wr_data[15:0]),
      .hdr        (hdr),
      .pay_len    (pay_len),
      .is_long    (is_long),
      .lp         (lp),
      .is_read    (is_read),
      .is_te      (is_te),
      .size_bad   (size_bad)
   );

   assign send_ok = send && !busy;
   assign start   = send_ok && !size_bad;

   dsi_cmd_tx #(.WORDS(WORDS)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .hdr         (hdr),
      .pay_len     (pay_len),
      .is_long     (is_long),
      .lp          (lp),
      .is_read     (is_read),
      .is_te       (is_te),
      .wr_data     (wr_data),
      .tx_ready    (tx_ready),
      .rsp_valid   (rsp_valid),
      .rsp_err     (rsp_err),
      .rsp_err_val (rsp_err_val),
      .rsp_data    (rsp_data),
      .rsp_size    (rsp_size),
      .tx_valid    (tx_valid),
      .tx_byte     (tx_byte),
      .tx_last     (tx_last),
      .tx_lp       (tx_lp),
      .busy        (busy),
      .ev_wr_done  (ev_wr_done),
      .ev_te       (ev_te),
      .ev_ack_err  (ev_ack_err),
      .ev_rd_err   (ev_rd_err),
      .ev_rd_done  (ev_rd_done),
      .err_val     (err_val),
      .rd_data     (rd_data),
      .rd_size     (rd_size)
   );

   always_comb begin
      set_ev            = '0;
      set_ev[F_WR_DONE] = ev_wr_done;
      set_ev[F_TE]      = ev_te;
      set_ev[F_ACK_ERR] = ev_ack_err;
      set_ev[F_RD_ERR]  = ev_rd_err;
      set_ev[F_COLLIDE] = send && busy;
      set_ev[F_SIZE]    = send_ok && size_bad;
      set_ev[F_RD_DONE] = ev_rd_done;
   end

   dsi_cmd_status #(.W(FLG_W)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ev   (set_ev),
      .clr_mask (clr_mask),
      .irq_en   (irq_en),
      .flags    (flags),
      .irq      (irq)
   );

   assign sts = {err_val, 9'b0, flags};

endmodule

// File: rtl/dsi_cmd_engine_chk.sv
module dsi_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       send,
   input logic       busy,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_byte,
   input logic       tx_last,
   input logic [6:0] sts_flags,
   input logic [6:0] clr_mask,
   input logic       irq
);

   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_valid);

   assert_hold_byte_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

   assert_done_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> (sts_flags[0] && busy));

   assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (send && busy) |=> sts_flags[4]);

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_flags & $past(sts_flags & ~clr_mask)) == $past(sts_flags & ~clr_mask)));

   assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (sts_flags != 7'd0));

endmodule

bind dsi_cmd_engine dsi_cmd_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .send      (send),
   .busy      (busy),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_byte   (tx_byte),
   .tx_last   (tx_last),
   .sts_flags (sts[6:0]),
   .clr_mask  (clr_mask),
   .irq       (irq)
);

// File: tb/tb_dsi_cmd_engine.sv
module tb_dsi_cmd_engine;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  cfg_word = '0;
   logic [127:0] wr_data = '0;
   logic         send = 1'b0;
   logic [6:0]   clr_mask = '0;
   logic [6:0]   irq_en = '0;
   logic         tx_valid, tx_last, tx_lp, busy, irq;
   logic [7:0]   tx_byte;
   logic         tx_ready = 1'b1;
   logic         rsp_valid = 1'b0, rsp_err = 1'b0;
   logic [15:0]  rsp_err_val = '0;
   logic [31:0]  rsp_data = '0;
   logic [2:0]   rsp_size = '0;
   logic [31:0]  sts, rd_data;
   logic [2:0]   rd_size;

   int checks = 0;
   int fails  = 0;
   logic [7:0] got_q[$];
   logic [7:0] exp_q[$];
   logic       first_lp;
   logic       exp_lp;

   always #10 clk = ~clk;

   dsi_cmd_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .wr_data(wr_data),
      .send(send), .clr_mask(clr_mask), .irq_en(irq_en),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_lp(tx_lp),
      .tx_ready(tx_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_err_val(rsp_err_val), .rsp_data(rsp_data), .rsp_size(rsp_size),
      .busy(busy), .sts(sts), .rd_data(rd_data), .rd_size(rd_size), .irq(irq)
   );

   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (got_q.size() == 0) first_lp = tx_lp;
         got_q.push_back(tx_byte);
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk_cfg(input int nat, input bit lng, input int vc,
                                          input int sz, input bit lp, input int dt);
      return {6'(dt), lp, 4'(sz), 2'(vc), lng, 2'(nat)};
   endfunction

   task automatic build_expect(input logic [15:0] c, input logic [127:0] d);
      logic [7:0]  di, p1, p2;
      logic [15:0] sum;
      int          sz;
      bit          lng;
      exp_q.delete();
      sz  = int'(c[8:5]);
      lng = c[2];
      if (c[1:0] == 2'd2) begin
         di = 8'h15; p1 = d[7:0]; p2 = d[15:8]; lng = 1'b0; exp_lp = 1'b1;
      end else begin
         di = {c[4:3], c[15:10]}; exp_lp = c[9];
         if (lng) begin
            p1 = 8'(sz); p2 = 8'h00;
         end else begin
            p1 = (sz >= 1) ? d[7:0] : 8'h00;
            p2 = (sz >= 2) ? d[15:8] : 8'h00;
         end
      end
      exp_q.push_back(di); exp_q.push_back(p1); exp_q.push_back(p2);
      exp_q.push_back(di ^ p1 ^ p2);
      if (lng) begin
         sum = '0;
         for (int i = 0; i < sz; i++) begin
            exp_q.push_back(d[8*i +: 8]);
            sum = sum + {8'h00, d[8*i +: 8]};
         end
         exp_q.push_back(sum[7:0]);
         exp_q.push_back(sum[15:8]);
      end
   endtask

   task automatic compare_stream(input string req);
      check({req, " byte count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         check($sformatf("%s byte %0d", req, i), got_q[i], exp_q[i]);
   endtask

   task automatic do_send(input logic [15:0] c, input logic [127:0] d);
      got_q.delete();
      build_expect(c, d);
      @(posedge clk); #2;
      cfg_word = c; wr_data = d; send = 1'b1;
      @(posedge clk); #2;
      send = 1'b0;
   endtask

   task automatic clear_all();
      @(posedge clk); #2; clr_mask = 7'h7F;
      @(posedge clk); #2; clr_mask = 7'h00;
      @(negedge clk);
   endtask

   task automatic wait_sent();
      while (!sts[0]) @(negedge clk);
   endtask

   task automatic respond(input bit err, input logic [15:0] ev, input logic [31:0] dat,
                          input logic [2:0] sz);
      repeat (3) @(posedge clk);
      #2;
      rsp_valid = 1'b1; rsp_err = err; rsp_err_val = ev; rsp_data = dat; rsp_size = sz;
      @(posedge clk); #2;
      rsp_valid = 1'b0; rsp_err = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 tx_valid", tx_valid, 0);
      check("R1 tx_last", tx_last, 0);
      check("R1 irq", irq, 0);
      check("R1 sts", sts, 0);
   endtask

   task automatic t_short_write();
      clear_all();
      do_send(mk_cfg(0, 0, 1, 1, 0, 6'h05), 128'hFF_A7);
      wait_sent();
      check("R5 busy while waiting", busy, 1);
      compare_stream("R2 short write");
      check("R9 lp low", first_lp, 0);
      check("R5 write done flag", sts[0], 1);
      respond(0, 16'h0, 32'h0, 3'd0);
      check("R5 idle after response", busy, 0);
   endtask

   task automatic t_long_write();
      clear_all();
      do_send(mk_cfg(0, 1, 2, 12, 1, 6'h39),
              128'hAAAA5555_0C0B0A09_08070605_04F302E1);
      wait_sent();
      compare_stream("R3 long write 12");
      check("R9 lp high", first_lp, 1);
      respond(0, 16'h0, 32'h0, 3'd0);
      clear_all();
      do_send(mk_cfg(3, 1, 0, 0, 0, 6'h29), 128'h1234);
      wait_sent();
      compare_stream("R3 empty long");
      respond(0, 16'h0, 32'h0, 3'd0);
   endtask

   task automatic t_oversize();
      clear_all();
      do_send(mk_cfg(0, 1, 0, 13, 0, 6'h39), 128'h1);
      repeat (6) @(negedge clk);
      check("R4 no bytes", got_q.size(), 0);
      check("R4 not busy", busy, 0);
      check("R4 size flag", sts[5], 1);
      check("R4 no write done", sts[0], 0);
   endtask

   task automatic t_read();
      clear_all();
      do_send(mk_cfg(1, 0, 0, 1, 1, 6'h06), 128'h0A);
      wait_sent();
      compare_stream("R2 read request");
      respond(0, 16'h0, 32'hDDCCBBAA, 3'd6);
      check("R7 rd_data", rd_data, 32'hDDCCBBAA);
      check("R7 rd_size clamp", rd_size, 4);
      check("R7 read done", sts[6], 1);
      clear_all();
      do_send(mk_cfg(1, 0, 0, 1, 1, 6'h06), 128'h0B);
      wait_sent();
      respond(0, 16'h0, 32'h00004321, 3'd2);
      check("R7 rd_size 2", rd_size, 2);
      check("R7 rd_data 2", rd_data, 32'h00004321);
   endtask

   task automatic t_errors();
      clear_all();
      do_send(mk_cfg(0, 0, 0, 2, 0, 6'h15), 128'h2211);
      wait_sent();
      respond(1, 16'hBEEF, 32'h0, 3'd0);
      check("R6 ack err flag", sts[2], 1);
      check("R6 err value", sts[31:16], 16'hBEEF);
      check("R6 no read err on write", sts[3], 0);
      clear_all();
      do_send(mk_cfg(1, 0, 0, 1, 0, 6'h06), 128'h33);
      wait_sent();
      respond(1, 16'h0123, 32'hFFFFFFFF, 3'd4);
      check("R6 read err flag", sts[3], 1);
      check("R6 err value read", sts[31:16], 16'h0123);
      check("R6 no read done", sts[6], 0);
   endtask

   task automatic t_te();
      clear_all();
      do_send(mk_cfg(2, 1, 3, 9, 0, 6'h3F), 128'h0135);
      wait_sent();
      compare_stream("R8 te request");
      check("R8 lp forced", first_lp, 1);
      respond(0, 16'h0, 32'h0, 3'd0);
      check("R8 te flag", sts[1], 1);
   endtask

   task automatic t_collision();
      clear_all();
      do_send(mk_cfg(0, 1, 0, 4, 0, 6'h39), 128'h44332211);
      @(posedge clk); #2;
      cfg_word = mk_cfg(0, 0, 1, 2, 1, 6'h05); send = 1'b1;
      @(posedge clk); #2; send = 1'b0;
      wait_sent();
      repeat (4) @(negedge clk);
      compare_stream("R10 single packet");
      check("R10 collision flag", sts[4], 1);
      respond(0, 16'h0, 32'h0, 3'd0);
      repeat (6) @(negedge clk);
      check("R10 no second packet", busy, 0);
   endtask

   task automatic t_clear_irq();
      clear_all();
      do_send(mk_cfg(0, 0, 0, 2, 0, 6'h15), 128'h2211);
      wait_sent();
      respond(1, 16'h5A5A, 32'h0, 3'd0);
      check("R12 irq off when disabled", irq, 0);
      @(posedge clk); #2; irq_en = 7'b0000100;
      @(negedge clk);
      check("R12 irq on", irq, 1);
      @(posedge clk); #2; clr_mask = 7'b0000001;
      @(posedge clk); #2; clr_mask = 7'b0;
      @(negedge clk);
      check("R11 cleared bit", sts[0], 0);
      check("R11 other bit kept", sts[2], 1);
      repeat (3) @(negedge clk);
      check("R11 still set", sts[2], 1);
      @(posedge clk); #2; clr_mask = 7'b0000100;
      @(posedge clk); #2; clr_mask = 7'b0;
      @(negedge clk);
      check("R11 ack err cleared", sts[2], 0);
      check("R12 irq drops", irq, 0);
      irq_en = 7'b0;
   endtask

   task automatic t_backpressure();
      logic [7:0] held;
      clear_all();
      tx_ready = 1'b0;
      do_send(mk_cfg(0, 1, 1, 3, 0, 6'h39), 128'h00C0B0A0);
      @(negedge clk);
      held = tx_byte;
      check("R13 valid asserted", tx_valid, 1);
      repeat (3) @(negedge clk);
      check("R13 valid held", tx_valid, 1);
      check("R13 byte held", tx_byte, held);
      @(posedge clk); #2; tx_ready = 1'b1;
      repeat (4) begin
         @(posedge clk); #2; tx_ready = ~tx_ready;
      end
      tx_ready = 1'b1;
      wait_sent();
      compare_stream("R13 stream under stalls");
      respond(0, 16'h0, 32'h0, 3'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short_write();
      t_long_write();
      t_oversize();
      t_read();
      t_errors();
      t_te();
      t_collision();
      t_clear_irq();
      t_backpressure();
      repeat (4) @(posedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule